// File: doc/BRIEF.md
# Reloadable Baud Clock Generator

This block is the timing source for a serial shift engine. It produces two single-cycle strobes. The shift tick marks the end of each bit period. The half tick marks the midpoint of each bit period, where an asynchronous receiver samples its data. The strobes come from one of two sources. The first is an internal reloadable divide-by-N counter, which gives a bit rate of Fsys/(2*N). The second is an external clock pin, which is synchronised into the system clock domain and can be inverted. For master modes, the block can also drive a clock output pin with either polarity.

Software or a sequencer sets the block up with a single 32-bit configuration word. Any write to that word restarts the divider at the start of a new bit period. A rate change therefore takes effect at once, and no bit goes out at the old rate.

Top module: `baud_clk_gen`

## Requirements
- R1: While reset is asserted, shift_tick, half_tick, clk_out and clk_out_oe are all 0.
- R2: The configuration word holds the divisor N in bits [31:16]. With bit 4 = 0 (internal source), a bit period lasts 2*N cycles. Count the cycles after the write edge, with the first cycle after the edge numbered 1. half_tick is high in cycles N, 3N, 5N and so on. shift_tick is high in cycles 2N, 4N and so on. Each pulse lasts one cycle.
- R3: A divisor field of 0 behaves exactly like a divisor of 1.
- R4: A configuration write reloads the divider at the write edge. The timing of R2 restarts from that edge, whatever point the previous bit period had reached.
- R5: Bits [1:0] select the clock output mode: 00 disabled, 01 reserved (acts as disabled), 10 true, 11 inverted. When the output is disabled, clk_out_oe = 0 and clk_out = 0. When it is enabled, clk_out_oe = 1. In true mode, with the internal source, clk_out is 0 for the first N cycles of each bit period and 1 for the last N cycles. Inverted mode gives the complement.
- R6: With N = 1, the internal clock output toggles on every cycle (Fsys/2). Half ticks and shift ticks then alternate on every cycle.
- R7: With bit 4 = 1 (external source), each rising edge of the input level pulses shift_tick for exactly one cycle, and each falling edge pulses half_tick for one cycle. The input level is taken after polarity correction. A change of ext_clk_in just before clock edge E shows up in the cycle after edge E+1.
- R8: Bits [3:2] select the external input mode, using the same coding as R5: 00 and 01 disabled, 10 true, 11 inverted. When the input is disabled, the external pin produces no ticks. Inverted mode swaps the roles of the raw rising and falling edges.
- R9: With the internal source selected, activity on ext_clk_in has no effect on the ticks or on clk_out.
- R10: With the external source and the clock output enabled, clk_out follows the synchronised, polarity-corrected input level, and the output inversion is applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word written when cfg_wr is high |
| ext_clk_in | input | 1 | External clock pin, asynchronous to clk |
| shift_tick | output | 1 | One-cycle strobe at the end of each bit period |
| half_tick | output | 1 | One-cycle strobe at the middle of each bit period |
| clk_out | output | 1 | Clock output level |
| clk_out_oe | output | 1 | Clock output enable |

## Verification
The internal divider is tried with the divisors 1, 2, 3, 4 and 5 and with a zero field. This separates an off-by-one in the reload from a wrong half-period split and from a missing clamp on a zero field. Each divisor is paired with a different output mode, so that the polarity and the enable coding are checked along the way. The external pin is toggled while the internal source is running, which shows whether the source multiplexer leaks. A mid-period rate change checks that the divider is re-primed at the write. The external source is driven in true, inverted and disabled modes; this tells an edge swap apart from a missing gate on the disabled coding, and shows whether the synchroniser latency is right.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

   // Two-bit pin mode coding shared by clock input and clock output fields
   typedef enum logic [1:0] {
      PM_OFF  = 2'b00,
      PM_RSVD = 2'b01,
      PM_TRUE = 2'b10,
      PM_INV  = 2'b11
   } pin_mode_e;

   // Field positions inside the configuration word
   localparam int OUT_LSB = 0;
   localparam int IN_LSB  = 2;
   localparam int SRC_BIT = 4;
   localparam int DIV_LSB = 16;

   function automatic logic pm_enabled(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic pm_inverted(input logic [1:0] m);
      return m[1] & m[0];
   endfunction

endpackage

// File: rtl/baud_div.sv
module baud_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [DIV_W-1:0] div_n,
   output logic             half_tick,
   output logic             full_tick,
   output logic             phase
);

   logic [DIV_W-1:0] hcnt;
   logic             ph;
   logic             live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         ph   <= 1'b0;
         live <= 1'b0;
      end else begin
         live <= 1'b1;
         if (load) begin
            hcnt <= div_n - DIV_W'(1);
            ph   <= 1'b0;
         end else if (hcnt == '0) begin
            hcnt <= div_n - DIV_W'(1);
            ph   <= ~ph;
         end else begin
            hcnt <= hcnt - DIV_W'(1);
         end
      end
   end

   assign half_tick = run && live && (hcnt == '0) && !ph;
   assign full_tick = run && live && (hcnt == '0) && ph;
   assign phase     = ph;

   AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(half_tick && full_tick)); // R2
   AST_HALF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick |=> !half_tick); // R2
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (hcnt == $past(div_n) - DIV_W'(1)) && !ph); // R4
   AST_N1_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (div_n == DIV_W'(1) && !load) |=> (ph != $past(ph))); // R6

endmodule

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   input  logic en,
   input  logic inv,
   output logic lvl,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] sr;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[0] <= 1'b0;
               else        sr[0] <= ext_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[i] <= 1'b0;
               else        sr[i] <= sr[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sr[STAGES-1];
   end

   logic raw, raw_r, raw_f;
   assign raw   = sr[STAGES-1];
   assign raw_r = raw & ~prev;
   assign raw_f = ~raw & prev;

   assign rise = en & (inv ? raw_f : raw_r);
   assign fall = en & (inv ? raw_r : raw_f);
   assign lvl  = en & (raw ^ inv);

   AST_EDGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (!rise || !$stable(inv))); // R7
   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall)); // R8

endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
   import baudgen_pkg::*;
#(
   parameter int CFG_W       = 32,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             ext_clk_in,
   output logic             shift_tick,
   output logic             half_tick,
   output logic             clk_out,
   output logic             clk_out_oe
);

   localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

   generate
      if (DIV_MSB >= CFG_W) begin : g_bad_div
         $error("divisor field does not fit in the configuration word");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchroniser stages are required");
      end
   endgenerate

   function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
      return (d == '0) ? DIV_W'(1) : d;
   endfunction

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= cfg_wdata;
   end

   logic [DIV_W-1:0] div_n;
   logic             src_ext;
   logic [1:0]       in_mode, out_mode;

   assign div_n    = cfg_wr ? clamp_div(cfg_wdata[DIV_MSB:DIV_LSB])
                            : clamp_div(cfg_q[DIV_MSB:DIV_LSB]);
   assign src_ext  = cfg_q[SRC_BIT];
   assign in_mode  = cfg_q[IN_LSB +: 2];
   assign out_mode = cfg_q[OUT_LSB +: 2];

   logic int_half, int_full, int_phase;

   baud_div #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (!src_ext),
      .load      (cfg_wr),
      .div_n     (div_n),
      .half_tick (int_half),
      .full_tick (int_full),
      .phase     (int_phase)
   );

   logic ext_lvl, ext_rise, ext_fall;

   baud_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ext_in (ext_clk_in),
      .en     (src_ext & pm_enabled(in_mode)),
      .inv    (pm_inverted(in_mode)),
      .lvl    (ext_lvl),
      .rise   (ext_rise),
      .fall   (ext_fall)
   );

   logic base_lvl;
   assign base_lvl   = src_ext ? ext_lvl  : int_phase;
   assign shift_tick = src_ext ? ext_rise : int_full;
   assign half_tick  = src_ext ? ext_fall : int_half;
   assign clk_out_oe = pm_enabled(out_mode);
   assign clk_out    = pm_enabled(out_mode) & (base_lvl ^ pm_inverted(out_mode));

   AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_out_oe |-> !clk_out); // R5
   AST_TICKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_tick && half_tick)); // R7

endmodule

// File: tb/sim_baud_clk_gen.sv
module sim_baud_clk_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        ext_clk_in = 1'b0;
   logic        shift_tick, half_tick, clk_out, clk_out_oe;

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   baud_clk_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .ext_clk_in (ext_clk_in),
      .shift_tick (shift_tick),
      .half_tick  (half_tick),
      .clk_out    (clk_out),
      .clk_out_oe (clk_out_oe)
   );

   // cfg = {divisor[31:16], 11'b0, src[4], in_mode[3:2], out_mode[1:0]}
   localparam logic [31:0] VEC [6] = '{
      {16'd3, 11'd0, 1'b0, 2'b00, 2'b10},
      {16'd1, 11'd0, 1'b0, 2'b00, 2'b11},
      {16'd4, 11'd0, 1'b0, 2'b10, 2'b00},
      {16'd0, 11'd0, 1'b0, 2'b00, 2'b10},
      {16'd2, 11'd0, 1'b0, 2'b11, 2'b01},
      {16'd5, 11'd0, 1'b0, 2'b00, 2'b11}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk);
      cfg_wdata = v;
      cfg_wr    = 1'b1;
      @(posedge clk);
      #1 cfg_wr = 1'b0;
   endtask

   // Checks the internal schedule for k = 1..span after a write
   task automatic run_internal(input int nn, input logic [1:0] om, input int span,
                               input string req, input bit wiggle);
      for (int k = 1; k <= span; k++) begin
         @(negedge clk);
         check({req, " half_tick"},  32'(half_tick),  32'((k % (2*nn)) == nn));
         check({req, " shift_tick"}, 32'(shift_tick), 32'((k % (2*nn)) == 0));
         check("R5 clk_out_oe", 32'(clk_out_oe), 32'(om[1]));
         check({req, " R5 clk_out"}, 32'(clk_out),
               32'(om[1] & ((((k-1)/nn) % 2 == 1) ^ (om[0] == 1'b1))));
         if (wiggle) ext_clk_in = ~ext_clk_in;   // R9: must not matter
      end
   endtask

   task automatic ext_step(input logic val, input bit exp_shift, input bit exp_half,
                           input bit exp_out, input string req);
      @(negedge clk);
      ext_clk_in = val;
      @(negedge clk);
      check({req, " k1 shift"}, 32'(shift_tick), 32'd0);
      check({req, " k1 half"},  32'(half_tick),  32'd0);
      @(negedge clk);
      check({req, " k2 shift"}, 32'(shift_tick), 32'(exp_shift));
      check({req, " k2 half"},  32'(half_tick),  32'(exp_half));
      check("R10 clk_out",      32'(clk_out),    32'(exp_out));
      @(negedge clk);
      check({req, " k3 shift"}, 32'(shift_tick), 32'd0);
      check({req, " k3 half"},  32'(half_tick),  32'd0);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 shift_tick", 32'(shift_tick), 32'd0);
      check("R1 half_tick",  32'(half_tick),  32'd0);
      check("R1 clk_out",    32'(clk_out),    32'd0);
      check("R1 clk_out_oe", 32'(clk_out_oe), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // Table walk: R2, R3, R5, R6, R9
      for (int v = 0; v < 6; v++) begin
         int nn;
         string req;
         nn  = (VEC[v][31:16] == 16'd0) ? 1 : int'(VEC[v][31:16]);
         req = (VEC[v][31:16] == 16'd0) ? "R3" : (nn == 1) ? "R6" : "R2";
         wr_cfg(VEC[v]);
         run_internal(nn, VEC[v][1:0], 4*nn, (VEC[v][3:2] != 2'b00) ? {req, " R9"} : req, 1'b1);
      end

      // R4: rate change in mid period restarts the schedule at the write
      wr_cfg({16'd2, 11'd0, 1'b0, 2'b00, 2'b10});
      repeat (3) @(negedge clk);
      wr_cfg({16'd6, 11'd0, 1'b0, 2'b00, 2'b10});
      run_internal(6, 2'b10, 12, "R4", 1'b0);

      // External source, true input, true output: R7, R10
      ext_clk_in = 1'b0;
      repeat (4) @(negedge clk);
      wr_cfg({16'd3, 11'd0, 1'b1, 2'b10, 2'b10});
      repeat (4) @(negedge clk);
      ext_step(1'b1, 1'b1, 1'b0, 1'b1, "R7 rise");
      ext_step(1'b0, 1'b0, 1'b1, 1'b0, "R7 fall");

      // External source, inverted input and output: R8, R10
      wr_cfg({16'd3, 11'd0, 1'b1, 2'b11, 2'b11});
      repeat (2) @(negedge clk);
      ext_step(1'b1, 1'b0, 1'b1, 1'b1, "R8 inv rise");
      ext_step(1'b0, 1'b1, 1'b0, 1'b0, "R8 inv fall");

      // External source, input disabled: R8
      wr_cfg({16'd3, 11'd0, 1'b1, 2'b00, 2'b10});
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check("R8 disabled shift", 32'(shift_tick), 32'd0);
         check("R8 disabled half",  32'(half_tick),  32'd0);
         ext_clk_in = ~ext_clk_in;
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule